// File: doc/BRIEF.md
# VME Address-Modifier Decoder with Register Slave

This block sits on the slave side of a VME board. It watches each bus cycle and sorts it by its address modifier into one of three classes. Emergency JTAG cycles go to a separate discrete loading engine. A24 cycles are register reads and writes. A32 cycles are data readout. For each cycle the block claims, it raises a one-clock select strobe for that class and drives DTACK until the master releases its data strobe.

The A24 space of the board is picked by five upper address bits, A[23:19]. In a crate with geographic addressing these bits come from the slot number. In an older crate they come from a switch. The block holds two A24 registers. The first is an identification word with a writable crate number. The second holds the base of the A32 readout window in its top nine bits. The window stays closed while that base is zero.

Strobes are brought into the clock domain through a parameterised synchronizer. A small state machine handles each cycle. Its states are ST_IDLE, ST_ACK and ST_SKIP. Its transitions are claim (ST_IDLE to ST_ACK on a matching cycle), decline (ST_IDLE to ST_SKIP on a cycle that matches nothing) and release (ST_ACK or ST_SKIP back to ST_IDLE once the synchronized data strobe goes high).

Top module: `vme_am_decoder`

## Requirements
- R1: A cycle is active when both as_n and ds_n are low. The address modifier sets the class: 0x19, 0x1A, 0x1D and 0x1E are emergency JTAG; 0x39, 0x3A, 0x3D and 0x3E are A24 register access; 0x09, 0x0A, 0x0B, 0x0D, 0x0E and 0x0F are A32 data. A claimed cycle raises exactly one of jtag_sel, reg_sel or data_sel, for exactly one clock, in the same cycle DTACK first goes high.
- R2: The A24 base is ga when vme64x is 1 and sw_base when it is 0. A24 and JTAG cycles whose A[23:19] differ from the base get no response.
- R3: A24 offset 0x00000 reads {BOARD_TYPE[31:24], BOARD_REV[23:16], 3'b000[15:13], A24 base[12:8], crate number[7:0]}. The crate number resets to 0x00. A write changes only bits 7:0.
- R4: A24 offset 0x00010 holds the A32 window base in bits 31:23 and resets to zero. All its other bits read zero.
- R5: An A32 cycle is claimed, with data_sel and DTACK and read data zero, only when the window base is nonzero and A[31:23] equals it. Every other A32 cycle gets no response.
- R6: A JTAG-class cycle is claimed, with jtag_sel, only at A24 offset 0x0FFFC, that is A[18:2] all ones in bits 15:2 and zero in bits 18:16. At any other offset it gets no response.
- R7: An A24 register cycle at offset 0x0FFFC is never claimed.
- R8: A24 register reads at any other unimplemented offset return zero and are acknowledged. Writes there change no register.
- R9: After reset, dtack, all select strobes and rdata are 0. DTACK stays high until ds_n is seen high, then drops. A cycle that is not claimed never raises DTACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vme_addr | input | 32 | Bus address A[31:0] |
| vme_am | input | 6 | Address modifier |
| vme_wdata | input | 32 | Write data from the master |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 1 | Data strobe, active low |
| vme_write_n | input | 1 | 0 = write cycle, 1 = read cycle |
| ga | input | 5 | Geographic slot address |
| vme64x | input | 1 | 1 = crate provides geographic address |
| sw_base | input | 5 | Switch value used as A24 base in older crates |
| rdata | output | 32 | Read data, valid while dtack is high |
| dtack | output | 1 | Data acknowledge, active high |
| jtag_sel | output | 1 | One-clock strobe for a claimed emergency JTAG cycle |
| reg_sel | output | 1 | One-clock strobe for a claimed A24 register cycle |
| data_sel | output | 1 | One-clock strobe for a claimed A32 data cycle |

## Verification
The hardest case to reach is an A32 cycle whose address matches a window base of zero. The cycle must still be declined, because a zero base means the window is closed. The bench drives that cycle straight after reset, while the base register still holds its reset value. Next it writes all ones to offset 0x00010, so the window opens at base 0x1FF. Then it drives one matching A32 cycle and one that misses. Offset 0x0FFFC is also driven with both the JTAG and the A24 modifiers, so both sides of that carve-out are checked.

// File: rtl/vme_dec_pkg.sv
package vme_dec_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_JTAG = 2'd1,
        CLS_REG  = 2'd2,
        CLS_DATA = 2'd3
    } acc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_SKIP = 2'd2
    } slv_state_e;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int AM_W   = 6;

endpackage

// File: rtl/vme_dec_sync.sv
module vme_dec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        stage_q[i] <= '1;
                    end else if (i == 0) begin
                        stage_q[i] <= din;
                    end else begin
                        stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
                    end
                end
            end
            assign dout = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/vme_dec_classify.sv
module vme_dec_classify
    import vme_dec_pkg::*;
#(
    parameter int          A24_BASE_W = 5,
    parameter int          A32_BASE_W = 9,
    parameter logic [31:0] JTAG_OFS   = 32'h0000_FFFC
) (
    input  logic [ADDR_W-1:2]     addr_w,
    input  logic [AM_W-1:0]       am,
    input  logic [A24_BASE_W-1:0] a24_base,
    input  logic [A32_BASE_W-1:0] a32_base,
    output acc_class_e            cls
);
    localparam int A24_OFS_W = 24 - A24_BASE_W;
    localparam int A32_LO    = ADDR_W - A32_BASE_W;

    logic am_jtag, am_a24, am_a32;
    logic a24_match, a32_match, at_jtag_ofs;

    always_comb begin
        unique case (am)
            6'h19, 6'h1A, 6'h1D, 6'h1E: am_jtag = 1'b1;
            default:                    am_jtag = 1'b0;
        endcase
        unique case (am)
            6'h39, 6'h3A, 6'h3D, 6'h3E: am_a24 = 1'b1;
            default:                    am_a24 = 1'b0;
        endcase
        unique case (am)
            6'h09, 6'h0A, 6'h0B,
            6'h0D, 6'h0E, 6'h0F:        am_a32 = 1'b1;
            default:                    am_a32 = 1'b0;
        endcase
    end

    assign a24_match   = (addr_w[23:A24_OFS_W] == a24_base);
    assign at_jtag_ofs = (addr_w[A24_OFS_W-1:2] == JTAG_OFS[A24_OFS_W-1:2]);
    assign a32_match   = (a32_base != '0) &&
                         (addr_w[ADDR_W-1:A32_LO] == a32_base);

    always_comb begin
        cls = CLS_NONE;
        if (am_jtag && a24_match && at_jtag_ofs) begin
            cls = CLS_JTAG;
        end else if (am_a24 && a24_match && !at_jtag_ofs) begin
            cls = CLS_REG;
        end else if (am_a32 && a32_match) begin
            cls = CLS_DATA;
        end
    end
endmodule

// File: rtl/vme_dec_regs.sv
module vme_dec_regs
    import vme_dec_pkg::*;
#(
    parameter int         A24_BASE_W = 5,
    parameter int         A32_BASE_W = 9,
    parameter int         CRATE_W    = 8,
    parameter logic [7:0] BOARD_TYPE = 8'h5C,
    parameter logic [7:0] BOARD_REV  = 8'h01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [16:0]            word_idx,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [A24_BASE_W-1:0]  a24_base,
    output logic [DATA_W-1:0]      rd_word,
    output logic [A32_BASE_W-1:0]  a32_base,
    output logic [CRATE_W-1:0]     crate_id
);
    localparam logic [16:0] ID_WORD   = 17'd0;
    localparam logic [16:0] BASE_WORD = 17'd4;
    localparam int          A32_LO    = DATA_W - A32_BASE_W;
    localparam int          GAP_W     = 16 - 8 - A24_BASE_W;

    logic unused_wdata;
    assign unused_wdata = ^wdata[A32_LO-1:CRATE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crate_id <= '0;
            a32_base <= '0;
        end else if (wr_en) begin
            if (word_idx == ID_WORD) begin
                crate_id <= wdata[CRATE_W-1:0];
            end
            if (word_idx == BASE_WORD) begin
                a32_base <= wdata[DATA_W-1:A32_LO];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (word_idx == ID_WORD) begin
            rd_word = {BOARD_TYPE, BOARD_REV, {GAP_W{1'b0}}, a24_base, crate_id};
        end else if (word_idx == BASE_WORD) begin
            rd_word = {a32_base, {A32_LO{1'b0}}};
        end
    end
endmodule

// File: rtl/vme_am_decoder.sv
module vme_am_decoder
    import vme_dec_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         A24_BASE_W  = 5,
    parameter int         A32_BASE_W  = 9,
    parameter logic [7:0] BOARD_TYPE  = 8'h5C,
    parameter logic [7:0] BOARD_REV   = 8'h01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           vme_addr,
    input  logic [5:0]            vme_am,
    input  logic [31:0]           vme_wdata,
    input  logic                  vme_as_n,
    input  logic                  vme_ds_n,
    input  logic                  vme_write_n,
    input  logic [4:0]            ga,
    input  logic                  vme64x,
    input  logic [4:0]            sw_base,
    output logic [31:0]           rdata,
    output logic                  dtack,
    output logic                  jtag_sel,
    output logic                  reg_sel,
    output logic                  data_sel
);
    localparam int CRATE_W = 8;

    logic [1:0]            strb_s;
    logic                  as_s, ds_s, active;
    logic [A24_BASE_W-1:0] a24_base;
    logic [A32_BASE_W-1:0] a32_base;
    logic [CRATE_W-1:0]    crate_id;
    logic [DATA_W-1:0]     rd_word;
    acc_class_e            cls;
    slv_state_e            state_q, state_n;
    logic                  claim, reg_wr;
    logic                  unused_addr_lo;

    assign unused_addr_lo = ^vme_addr[1:0];

    vme_dec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({vme_as_n, vme_ds_n}),
        .dout (strb_s)
    );
    assign as_s   = strb_s[1];
    assign ds_s   = strb_s[0];
    assign active = !as_s && !ds_s;

    assign a24_base = vme64x ? ga : sw_base;

    vme_dec_classify #(.A24_BASE_W(A24_BASE_W), .A32_BASE_W(A32_BASE_W)) u_cls (
        .addr_w  (vme_addr[31:2]),
        .am      (vme_am),
        .a24_base(a24_base),
        .a32_base(a32_base),
        .cls     (cls)
    );

    vme_dec_regs #(
        .A24_BASE_W(A24_BASE_W), .A32_BASE_W(A32_BASE_W), .CRATE_W(CRATE_W),
        .BOARD_TYPE(BOARD_TYPE), .BOARD_REV(BOARD_REV)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .word_idx(vme_addr[18:2]),
        .wdata   (vme_wdata),
        .a24_base(a24_base),
        .rd_word (rd_word),
        .a32_base(a32_base),
        .crate_id(crate_id)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state: claim, decline, release
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (active) state_n = (cls != CLS_NONE) ? ST_ACK : ST_SKIP;
            ST_ACK:  if (ds_s)   state_n = ST_IDLE;
            ST_SKIP: if (ds_s)   state_n = ST_IDLE;
            default:             state_n = ST_IDLE;
        endcase
    end

    assign claim  = (state_q == ST_IDLE) && (state_n == ST_ACK);
    assign reg_wr = claim && (cls == CLS_REG) && !vme_write_n;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dtack    <= 1'b0;
            jtag_sel <= 1'b0;
            reg_sel  <= 1'b0;
            data_sel <= 1'b0;
            rdata    <= '0;
        end else begin
            dtack    <= (state_n == ST_ACK);
            jtag_sel <= claim && (cls == CLS_JTAG);
            reg_sel  <= claim && (cls == CLS_REG);
            data_sel <= claim && (cls == CLS_DATA);
            if (claim) begin
                rdata <= ((cls == CLS_REG) && vme_write_n) ? rd_word : '0;
            end
        end
    end
endmodule

// File: rtl/vme_am_decoder_chk.sv
module vme_am_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dtack,
    input logic        jtag_sel,
    input logic        reg_sel,
    input logic        data_sel,
    input logic        ds_s,
    input logic [31:0] vme_addr,
    input logic [8:0]  a32_base,
    input logic [7:0]  crate_id
);
    assert_onehot_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jtag_sel, reg_sel, data_sel}));

    assert_sel_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_sel || reg_sel || data_sel) |=> !(jtag_sel || reg_sel || data_sel));

    assert_sel_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_sel || reg_sel || data_sel) |-> dtack);

    assert_dtack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack) |-> $past(ds_s));

    assert_window_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_sel |-> (a32_base != 9'd0));

    assert_jtag_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        jtag_sel |-> (vme_addr[18:2] == 17'h03FFF));

    assert_reg_not_jtag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (vme_addr[18:2] != 17'h03FFF));

    assert_crate_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(crate_id) |-> reg_sel);
endmodule

bind vme_am_decoder vme_am_decoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dtack   (dtack),
    .jtag_sel(jtag_sel),
    .reg_sel (reg_sel),
    .data_sel(data_sel),
    .ds_s    (ds_s),
    .vme_addr(vme_addr),
    .a32_base(a32_base),
    .crate_id(crate_id)
);

// File: tb/vme_am_decoder_tb.sv
`timescale 1ns/1ps
module vme_am_decoder_tb;
    localparam logic [7:0] BTYPE = 8'h5C;
    localparam logic [7:0] BREV  = 8'h01;
    localparam logic [2:0] SEL_NONE = 3'b000;
    localparam logic [2:0] SEL_J = 3'b100;
    localparam logic [2:0] SEL_R = 3'b010;
    localparam logic [2:0] SEL_D = 3'b001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] vme_addr = '0;
    logic [5:0]  vme_am = '0;
    logic [31:0] vme_wdata = '0;
    logic        vme_as_n = 1'b1;
    logic        vme_ds_n = 1'b1;
    logic        vme_write_n = 1'b1;
    logic [4:0]  ga = 5'd5;
    logic        vme64x = 1'b1;
    logic [4:0]  sw_base = 5'h13;
    logic [31:0] rdata;
    logic        dtack, jtag_sel, reg_sel, data_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vme_am_decoder #(.BOARD_TYPE(BTYPE), .BOARD_REV(BREV)) u_dut (
        .clk(clk), .rst_n(rst_n), .vme_addr(vme_addr), .vme_am(vme_am),
        .vme_wdata(vme_wdata), .vme_as_n(vme_as_n), .vme_ds_n(vme_ds_n),
        .vme_write_n(vme_write_n), .ga(ga), .vme64x(vme64x), .sw_base(sw_base),
        .rdata(rdata), .dtack(dtack), .jtag_sel(jtag_sel), .reg_sel(reg_sel),
        .data_sel(data_sel)
    );

    typedef struct {
        bit        ack;
        bit [2:0]  sel;
        bit [31:0] rd;
        bit        chk_rd;
        string     tag;
    } exp_t;

    exp_t exp_q[$];

    function automatic bit [31:0] id_word(input bit [4:0] base, input bit [7:0] crate);
        return {BTYPE, BREV, 3'b000, base, crate};
    endfunction

    // driver: push expectation, run one bus cycle
    task automatic cyc(input bit [5:0] am, input bit [31:0] addr, input bit wr,
                       input bit [31:0] wd, input bit ack, input bit [2:0] sel,
                       input bit [31:0] rd, input string tag);
        exp_t e;
        e.ack = ack; e.sel = sel; e.rd = rd; e.chk_rd = ack && !wr; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        vme_am = am; vme_addr = addr; vme_write_n = !wr; vme_wdata = wd;
        vme_as_n = 1'b0; vme_ds_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(posedge clk); #1;
            if (dtack) break;
        end
        @(negedge clk);
        vme_as_n = 1'b1; vme_ds_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // monitor: observe each cycle and compare against the scoreboard
    initial begin
        bit in_cyc = 0;
        bit seen_ack = 0;
        bit [2:0] seen_sel = '0;
        bit [31:0] got_rd = '0;
        forever begin
            @(posedge clk); #1;
            if (!in_cyc && !vme_as_n) begin
                in_cyc = 1; seen_ack = 0; seen_sel = '0; got_rd = '0;
            end
            if (in_cyc) begin
                if (dtack) begin seen_ack = 1; got_rd = rdata; end
                seen_sel = seen_sel | {jtag_sel, reg_sel, data_sel};
                if (vme_as_n) begin
                    in_cyc = 0;
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL unexpected cycle: ack=%0b sel=%b", seen_ack, seen_sel);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (seen_ack != e.ack || seen_sel != e.sel ||
                            (e.chk_rd && got_rd != e.rd)) begin
                            errors++;
                            $display("FAIL %s: ack=%0b sel=%b rd=%08h expected ack=%0b sel=%b rd=%08h",
                                     e.tag, seen_ack, seen_sel, got_rd, e.ack, e.sel, e.rd);
                        end
                    end
                end
            end
        end
    end

    task automatic direct(input bit ok, input string msg);
        checks++;
        if (!ok) begin errors++; $display("FAIL %s", msg); end
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        @(posedge clk); #1;
        direct(dtack == 0 && {jtag_sel, reg_sel, data_sel} == 0 && rdata == 0,
               $sformatf("R9 reset outputs: dtack=%0b sel=%b rdata=%08h expected 0 0 0",
                         dtack, {jtag_sel, reg_sel, data_sel}, rdata));
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3: ID word, geographic base 5, crate number reset 0
        cyc(6'h39, 32'h0028_0000, 0, 0, 1, SEL_R, id_word(5'd5, 8'h00), "R3 id word after reset");
        // R4: base register reset
        cyc(6'h3D, 32'h0028_0010, 0, 0, 1, SEL_R, 32'h0, "R4 window base reset zero");
        // R5: A32 with zero base is declined even though A[31:23] equals 0
        cyc(6'h09, 32'h0000_0040, 0, 0, 0, SEL_NONE, 0, "R5 closed window declined");
        // R3: write crate number with all other bits set
        cyc(6'h39, 32'h0028_0000, 1, 32'hFFFF_FFA7, 1, SEL_R, 0, "R3 crate write ack");
        cyc(6'h3A, 32'h0028_0000, 0, 0, 1, SEL_R, id_word(5'd5, 8'hA7), "R3 read-only fields kept");
        // R2: another slot's base is ignored
        cyc(6'h39, 32'h0030_0000, 0, 0, 0, SEL_NONE, 0, "R2 other base ignored");
        // R4: program A32 base
        cyc(6'h39, 32'h0028_0010, 1, 32'hFFFF_FFFF, 1, SEL_R, 0, "R4 base write ack");
        cyc(6'h39, 32'h0028_0010, 0, 0, 1, SEL_R, 32'hFF80_0000, "R4 base readback");
        // R5: window hit and miss
        cyc(6'h0B, 32'hFF80_0040, 0, 0, 1, SEL_D, 32'h0, "R5 window hit");
        cyc(6'h0F, 32'h7F80_0040, 0, 0, 0, SEL_NONE, 0, "R5 window miss");
        // R6 R7: JTAG offset carve-out
        cyc(6'h1D, 32'h0028_FFFC, 1, 32'h2, 1, SEL_J, 0, "R6 jtag claimed");
        cyc(6'h19, 32'h0028_FFF8, 1, 32'h1, 0, SEL_NONE, 0, "R6 jtag wrong offset");
        cyc(6'h3D, 32'h0028_FFFC, 0, 0, 0, SEL_NONE, 0, "R7 a24 at jtag offset");
        // R8: unimplemented offsets
        cyc(6'h39, 32'h0028_0100, 1, 32'hFFFF_FFFF, 1, SEL_R, 0, "R8 unimpl write ack");
        cyc(6'h39, 32'h0028_0100, 0, 0, 1, SEL_R, 32'h0, "R8 unimpl read zero");
        cyc(6'h39, 32'h0028_0000, 0, 0, 1, SEL_R, id_word(5'd5, 8'hA7), "R8 id unchanged");
        cyc(6'h39, 32'h0028_0010, 0, 0, 1, SEL_R, 32'hFF80_0000, "R8 base unchanged");
        // R1: unsupported modifier
        cyc(6'h3F, 32'h0028_0000, 0, 0, 0, SEL_NONE, 0, "R1 unknown modifier");
        // R2: switch-selected base
        @(negedge clk); vme64x = 1'b0;
        cyc(6'h39, 32'h0098_0000, 0, 0, 1, SEL_R, id_word(5'h13, 8'hA7), "R2 switch base read");
        cyc(6'h39, 32'h0028_0000, 0, 0, 0, SEL_NONE, 0, "R2 slot base unused");
        cyc(6'h1E, 32'h0098_FFFC, 1, 0, 1, SEL_J, 0, "R6 jtag at switch base");
        @(negedge clk); vme64x = 1'b1;
        // R9: dtack dropped after release
        @(posedge clk); #1;
        direct(dtack == 0, $sformatf("R9 dtack after release: %0b expected 0", dtack));

        repeat (4) @(negedge clk);
        direct(exp_q.size() == 0, $sformatf("R1 scoreboard drained: %0d left expected 0", exp_q.size()));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule